// File: doc/BRIEF.md
# Spike-Timing Surrogate Gradient Unit

This unit produces the local error term that spike-based backpropagation assigns to one output neuron. It receives four numbers about that neuron for one training step. A flag says whether the neuron fired. The other three are the slope of its membrane potential where it crossed threshold, its actual spike time, and its target spike time. All values are signed Q8.8 fixed point: two's complement, with the real value equal to the raw integer divided by 256. The error is the timing mismatch multiplied by the spike-time sensitivity. That sensitivity is minus one over the slope, because a faster rising potential moves the spike earlier.

The plain reciprocal has two failure cases. A neuron that never fired has no slope. A crossing that barely grazes threshold has a slope near zero. The unit replaces a silent neuron's slope with a fixed ensemble value, threshold divided by the window length, and treats its spike time as the end of the window. It raises any measured slope below a preset floor K up to that floor. K, the threshold and the window are elaboration-time constants. The reciprocal is formed by an iterative restoring divider. As a result the unit takes one operand set at a time and returns its answer a fixed number of cycles later.

Top module: `sg_unit`

## Requirements
- R1: With in_fired=1 and in_slope ≥ K_SLOPE (raw), out_err = −⌊d·r/256⌋, where d = in_t_act − in_t_tgt and r = ⌊65536/in_slope⌋, all in raw Q8.8 integers, then saturated as in R4.
- R2: With in_fired=1 and in_slope below K_SLOPE (zero and negative values included), the unit computes as in R1 with K_SLOPE in place of in_slope. The default K_SLOPE is 16, which is 0.0625.
- R3: With in_fired=0, the slope used is ⌊THETA·256/WINDOW⌋ (default 512·256/4096 = 32) and the actual time used is WINDOW (default 4096, which is 16.0). The in_slope and in_t_act values do not affect out_err.
- R4: The final result saturates to the range −32768 to 32767 rather than wrapping.
- R5: An operand set accepted on a rising edge (in_valid=1 while in_ready=1) produces out_valid high for exactly one cycle. The pulse comes from the 18th rising edge after the accepting edge, which is 2·FRAC_W+2 edges with FRAC_W=8. No other pulse appears.
- R6: in_ready falls at the accepting edge and rises again at the edge that raises out_valid. Operands presented while in_ready=0 are ignored and produce no output.
- R7: While reset (rst_n=0) is held, in_ready=1, out_valid=0 and out_err=0.
- R8: out_err changes only on the edge that raises out_valid and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can accept an operand set |
| in_fired | input | 1 | 1 when the neuron produced a spike in the window |
| in_slope | input | 16 | Membrane slope at the threshold crossing, signed Q8.8 |
| in_t_act | input | 16 | Actual spike time, signed Q8.8 |
| in_t_tgt | input | 16 | Target spike time, signed Q8.8 |
| out_valid | output | 1 | One-cycle pulse marking a new error term |
| out_err | output | 16 | Signed Q8.8 error term, held between pulses |

## Verification
The cycle that delivers one result is also the first cycle in which in_ready is high again. Handing off a finished term and accepting the next operand set can therefore happen on the same edge. The bench provokes this by holding in_valid high with the next operands while the unit is busy. A behavioural model that knows only the fixed latency predicts when each pulse should appear. Every cycle, the bench compares out_valid, out_err and in_ready with that model. The model would diverge from the design if a held operand set were taken early, late or twice. Inside the same busy windows, the bench drives junk operands and confirms that none of them yields a pulse.

// File: rtl/sg_pkg.sv
package sg_pkg;
   // rounding applied when the scaled product drops its fraction bits
   typedef enum logic {
      RND_FLOOR   = 1'b0,
      RND_HALF_UP = 1'b1
   } sg_rnd_e;
endpackage

// File: rtl/sg_select.sv
// Chooses the slope and time difference that feed the divider and scaler.
module sg_select #(
   parameter int W         = 16,
   parameter int K_SLOPE   = 16,
   parameter int ENS_SLOPE = 32,
   parameter int WINDOW    = 4096
) (
   input  logic                fired,
   input  logic signed [W-1:0] slope,
   input  logic signed [W-1:0] t_act,
   input  logic signed [W-1:0] t_tgt,
   output logic        [W-1:0] s_eff,
   output logic signed [W:0]   diff
);
   localparam logic signed [W-1:0] K_V   = W'(K_SLOPE);
   localparam logic signed [W-1:0] ENS_V = W'(ENS_SLOPE);
   localparam logic signed [W-1:0] WIN_V = W'(WINDOW);

   logic signed [W-1:0] t_use;

   always_comb begin
      if (!fired) begin
         s_eff = ENS_V;
      end else if (slope < K_V) begin
         s_eff = K_V;
      end else begin
         s_eff = slope;
      end
      t_use = fired ? t_act : WIN_V;
      diff  = (W+1)'(t_use) - (W+1)'(t_tgt);
   end
endmodule

// File: rtl/sg_recip_div.sv
// Restoring divider: quot = floor(2^(DIV_W-1) / divisor), one bit per cycle.
module sg_recip_div #(
   parameter int W     = 16,
   parameter int DIV_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [W-1:0]     divisor,
   output logic             done,
   output logic [DIV_W-1:0] quot
);
   localparam int CNT_W = $clog2(DIV_W + 1);
   localparam int PW    = DIV_W + W;
   localparam logic [DIV_W-1:0] NUM   = {1'b1, {(DIV_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] CNT_0 = CNT_W'(DIV_W);
   localparam logic [CNT_W-1:0] CNT_1 = CNT_W'(1);

   logic [DIV_W-1:0] num_q;
   logic [W-1:0]     rem_q;
   logic [W-1:0]     dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [W:0]       rem_sh;
   logic [W-1:0]     rem_sub;
   logic             ge;

   assign rem_sh  = {rem_q, num_q[DIV_W-1]};
   assign ge      = rem_sh >= {1'b0, dvs_q};
   assign rem_sub = rem_sh[W-1:0] - dvs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q <= '0;
         rem_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         done  <= 1'b0;
         quot  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            num_q <= NUM;
            rem_q <= '0;
            dvs_q <= divisor;
            cnt_q <= CNT_0;
            run_q <= 1'b1;
            quot  <= '0;
         end else if (run_q) begin
            rem_q <= ge ? rem_sub : rem_sh[W-1:0];
            quot  <= {quot[DIV_W-2:0], ge};
            num_q <= {num_q[DIV_W-2:0], 1'b0};
            cnt_q <= cnt_q - CNT_1;
            if (cnt_q == CNT_1) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

   // quotient bound check: q*d <= N and N - q*d < d
   logic [PW-1:0] chk_prod;
   logic [PW-1:0] chk_num;
   logic [PW-1:0] chk_dvs;
   assign chk_prod = {{W{1'b0}}, quot} * {{DIV_W{1'b0}}, dvs_q};
   assign chk_num  = {{W{1'b0}}, NUM};
   assign chk_dvs  = {{DIV_W{1'b0}}, dvs_q};

   assert_quot_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((chk_prod <= chk_num) && ((chk_num - chk_prod) < chk_dvs)))
      else $error("reciprocal quotient out of bounds");
endmodule

// File: rtl/sg_scale.sv
// Multiplies time difference by reciprocal, negates, drops fraction, saturates.
module sg_scale #(
   parameter int             W        = 16,
   parameter int             FRAC_W   = 8,
   parameter int             DIV_W    = 17,
   parameter sg_pkg::sg_rnd_e RND_MODE = sg_pkg::RND_FLOOR
) (
   input  logic signed [W:0]       diff,
   input  logic        [DIV_W-1:0] recip,
   output logic signed [W-1:0]     err
);
   localparam int PW = W + DIV_W + 3;
   localparam logic signed [PW-1:0] HI = PW'((1 << (W-1)) - 1);
   localparam logic signed [PW-1:0] LO = -HI - PW'(1);

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;
   logic signed [PW-1:0] neg;

   assign prod = PW'(diff) * PW'($signed({1'b0, recip}));

   generate
      if (RND_MODE == sg_pkg::RND_FLOOR) begin : g_floor
         assign shifted = prod >>> FRAC_W;
      end else begin : g_half
         localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC_W - 1);
         assign shifted = (prod + HALF) >>> FRAC_W;
      end
   endgenerate

   always_comb begin
      neg = -shifted;
      if (neg > HI) begin
         err = HI[W-1:0];
      end else if (neg < LO) begin
         err = LO[W-1:0];
      end else begin
         err = neg[W-1:0];
      end
   end
endmodule

// File: rtl/sg_unit.sv
// Spike-timing surrogate gradient unit, fixed latency, single operand in flight.
module sg_unit #(
   parameter int              INT_W    = 8,
   parameter int              FRAC_W   = 8,
   parameter int              K_SLOPE  = 16,
   parameter int              THETA    = 512,
   parameter int              WINDOW   = 4096,
   parameter sg_pkg::sg_rnd_e RND_MODE = sg_pkg::RND_FLOOR
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic                        in_fired,
   input  logic signed [INT_W+FRAC_W-1:0] in_slope,
   input  logic signed [INT_W+FRAC_W-1:0] in_t_act,
   input  logic signed [INT_W+FRAC_W-1:0] in_t_tgt,
   output logic                        out_valid,
   output logic signed [INT_W+FRAC_W-1:0] out_err
);
   localparam int W         = INT_W + FRAC_W;
   localparam int DIV_W     = 2 * FRAC_W + 1;
   localparam int ENS_SLOPE = (THETA * (1 << FRAC_W)) / WINDOW;
   localparam logic [W-1:0] K_V = W'(K_SLOPE);

   generate
      if (FRAC_W < 1 || INT_W < 2) begin : g_bad_width
         $error("sg_unit: INT_W must be >= 2 and FRAC_W >= 1");
      end
      if (K_SLOPE < 1 || K_SLOPE >= (1 << (W-1))) begin : g_bad_k
         $error("sg_unit: K_SLOPE must be positive and representable");
      end
      if (WINDOW < 1 || WINDOW >= (1 << (W-1))) begin : g_bad_window
         $error("sg_unit: WINDOW must be positive and representable");
      end
      if (ENS_SLOPE < 1 || ENS_SLOPE >= (1 << (W-1))) begin : g_bad_ens
         $error("sg_unit: THETA/WINDOW must give a representable positive slope");
      end
   endgenerate

   logic              accept;
   logic              busy_q;
   logic [W-1:0]      s_sel;
   logic signed [W:0] d_sel;
   logic signed [W:0] d_q;
   logic              div_done;
   logic [DIV_W-1:0]  recip;
   logic signed [W-1:0] err_c;

   assign in_ready = !busy_q;
   assign accept   = in_valid && !busy_q;

   sg_select #(
      .W(W), .K_SLOPE(K_SLOPE), .ENS_SLOPE(ENS_SLOPE), .WINDOW(WINDOW)
   ) sel_i (
      .fired(in_fired), .slope(in_slope), .t_act(in_t_act), .t_tgt(in_t_tgt),
      .s_eff(s_sel), .diff(d_sel)
   );

   sg_recip_div #(
      .W(W), .DIV_W(DIV_W)
   ) div_i (
      .clk(clk), .rst_n(rst_n), .start(accept), .divisor(s_sel),
      .done(div_done), .quot(recip)
   );

   sg_scale #(
      .W(W), .FRAC_W(FRAC_W), .DIV_W(DIV_W), .RND_MODE(RND_MODE)
   ) scl_i (
      .diff(d_q), .recip(recip), .err(err_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         d_q       <= '0;
         out_valid <= 1'b0;
         out_err   <= '0;
      end else begin
         out_valid <= div_done;
         if (accept) begin
            busy_q <= 1'b1;
            d_q    <= d_sel;
         end
         if (div_done) begin
            busy_q  <= 1'b0;
            out_err <= err_c;
         end
      end
   end

   assert_slope_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_fired) |-> (s_sel >= K_V))
      else $error("divisor below slope floor");

   assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid)
      else $error("out_valid longer than one cycle");

   assert_busy_before_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(!in_ready))
      else $error("result without a busy interval");

   assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_err))
      else $error("out_err moved without out_valid");
endmodule

// File: tb/sg_unit_tb_top.sv
module sg_unit_tb_top;
   localparam int INT_W  = 8;
   localparam int FRAC_W = 8;
   localparam int K      = 16;
   localparam int THETA  = 512;
   localparam int WIN    = 4096;
   localparam int LAT    = 2 * FRAC_W + 2;
   localparam int ENS    = (THETA * 256) / WIN;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic in_valid = 1'b0;
   logic in_fired = 1'b0;
   logic signed [15:0] in_slope = '0;
   logic signed [15:0] in_t_act = '0;
   logic signed [15:0] in_t_tgt = '0;
   logic in_ready;
   logic out_valid;
   logic signed [15:0] out_err;

   sg_unit #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .K_SLOPE(K), .THETA(THETA), .WINDOW(WIN),
      .RND_MODE(sg_pkg::RND_FLOOR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_fired(in_fired), .in_slope(in_slope), .in_t_act(in_t_act),
      .in_t_tgt(in_t_tgt), .out_valid(out_valid), .out_err(out_err)
   );

   int     n_chk = 0;
   int     n_bad = 0;
   int     cyc = 0;
   int     ready_at = 0;
   longint last_err = 0;
   bit     finished = 1'b0;
   int     q_due[$];
   longint q_err[$];
   string  q_tag[$];

   task automatic check(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic longint ref_err(bit f, int s, int ta, int tt);
      longint se, tu, d, r, p, e;
      se = !f ? ENS : ((s < K) ? K : s);
      tu = f ? ta : WIN;
      d  = tu - tt;
      r  = 65536 / se;
      p  = (d * r) >>> 8;
      e  = -p;
      if (e > 32767) e = 32767;
      if (e < -32768) e = -32768;
      return e;
   endfunction

   task automatic step(bit v, bit f, int s, int ta, int tt, string tag, output bit acc);
      bit exp_v;
      bit exp_r;
      @(negedge clk);
      exp_v = (q_due.size() > 0) && (q_due[0] == cyc);
      check("R5", "out_valid", longint'(out_valid), longint'(exp_v));
      if (exp_v) begin
         check(q_tag[0], "out_err", longint'(out_err), q_err[0]);
         last_err = q_err[0];
         void'(q_due.pop_front());
         void'(q_err.pop_front());
         void'(q_tag.pop_front());
      end else begin
         check("R8", "out_err hold", longint'(out_err), last_err);
      end
      exp_r = (cyc >= ready_at);
      check("R6", "in_ready", longint'(in_ready), longint'(exp_r));
      in_valid = v;
      in_fired = f;
      in_slope = 16'(s);
      in_t_act = 16'(ta);
      in_t_tgt = 16'(tt);
      acc = v && exp_r;
      if (acc) begin
         q_due.push_back(cyc + LAT + 1);
         q_err.push_back(ref_err(f, s, ta, tt));
         q_tag.push_back(tag);
         ready_at = cyc + LAT + 1;
      end
      cyc++;
   endtask

   task automatic send(string tag, bit f, int s, int ta, int tt);
      bit acc = 1'b0;
      while (!acc) step(1'b1, f, s, ta, tt, tag, acc);
   endtask

   task automatic idle(int n);
      bit acc;
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, "R6", acc);
   endtask

   // operands offered while busy must not be taken (R6)
   task automatic junk(int n);
      bit acc;
      for (int i = 0; i < n; i++) step(1'b1, i[0], 300 + 7 * i, -900 + 50 * i, 2000 - 33 * i, "R6", acc);
   endtask

   task automatic report();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R7", "in_ready in reset", longint'(in_ready), 1);
      check("R7", "out_valid in reset", longint'(out_valid), 0);
      check("R7", "out_err in reset", longint'(out_err), 0);
      rst_n = 1'b1;

      // R1 fired, slope at or above the floor
      send("R1", 1'b1, 256, 1280, 1024);
      send("R1", 1'b1, 768, 256, 2560);
      send("R1", 1'b1, 1000, 300, 301);
      send("R1", 1'b1, 16, 700, 500);
      send("R1", 1'b1, 4097, -3000, 3000);
      // R2 slope below the floor is replaced by K
      send("R2", 1'b1, 5, 1200, 1000);
      send("R2", 1'b1, 0, 100, 900);
      send("R2", 1'b1, -300, 2048, 1024);
      send("R2", 1'b1, 15, 1024, 1000);
      // R3 silent neuron: slope and actual time are ignored
      send("R3", 1'b1, 32, WIN, 4000);
      send("R3", 1'b0, 9999, -5000, 4000);
      send("R3", 1'b0, -7, 123, -2000);
      junk(10);
      idle(LAT);
      // R4 saturation both ways
      send("R4", 1'b1, 16, 12000, -12000);
      send("R4", 1'b1, 1, -12000, 12000);
      send("R4", 1'b0, 0, 0, -30000);
      idle(LAT + 4);
      check("R5", "pending results", longint'(q_due.size()), 0);
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         report();
      end
   end
endmodule